// File: doc/BRIEF.md
# Serial ADC Register Interface Controller

This block is the digital register interface of a two-channel sigma-delta converter. A host reaches it over a bit-serial port made of a serial clock, a data input and a data output. Every exchange opens with an 8-bit command byte. That byte selects a target register, the transfer direction, a power-down request and the active input channel. The data phase that follows moves the selected register at its own width: 8, 16 or 24 bits. Some selections have no data phase at all. After them, the next byte is taken as a new command.

The block holds the setup and clock registers and three offset/gain calibration pairs. The channel code chooses which pair is presented to the converter. A stand-in converter model signals a finished conversion with a one-cycle strobe and a 16-bit result. The block loads the result into the data register only while conversions run and no unread result is pending. It then drives an active-low data-ready flag. The flag stays low when the filter-sync bit stops conversion. Only a complete read of the data register clears it.

The serial clock and data input are brought into the system clock domain through a short synchronizer. The serial-clock edges are then detected from the synchronized samples.

Top module: `adc_regif`

## Requirements
- R1: After reset, setup reads 0x01, clock reads 0x85, every offset register reads 0x1F4000 and every gain register reads 0x5761AB. Data-ready (drdyN) is 1, sdo is 1, and both powerDown and chanSel are 0.
- R2: The command byte is sent with bit 7 first. Bit 7 must be 0. Bits 6:4 select the register: 000 communications, 001 setup, 010 clock, 011 data, 100 test, 101 no-operation, 110 offset, 111 gain. Bit 3 set to 1 means read. Bit 2 is power-down and bits 1:0 are the channel. powerDown and chanSel follow the last accepted command byte and change at no other time.
- R3: A 1 in the first bit position of a command byte is discarded. The interface keeps waiting for a command start, so a valid command sent afterwards works normally.
- R4: The data phase lasts 8 bits for setup, clock and a communications read. It lasts 16 bits for data and 24 bits for offset and gain. A communications write, test or no-operation has no data phase; the next byte is a command.
- R5: Data moves most significant bit first. sdi is sampled on a rising serial clock, and sdo changes only after a falling serial clock. sdo is 1 everywhere except the data phase of a read.
- R6: Channel code 00 and 10 select calibration pair 0, 01 selects pair 1 and 11 selects pair 2. Offset and gain transfers act on that pair, and activeOffset/activeGain present it.
- R7: In a communications read, the first bit returned is the current drdyN. The remaining seven bits are bits 6:0 of that read command.
- R8: convDone loads convResult into the data register and drives drdyN to 0 only when all of these hold: setup bit 0 (filter sync) is 0, powerDown is 0 and drdyN is 1. Otherwise convDone is ignored.
- R9: drdyN stays 0 when filter sync is set to 1. It returns to 1 only on the last bit of a 16-bit read of the data register.
- R10: A write to the data register takes 16 bits and changes neither the stored result nor drdyN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock, idle low |
| sdi | input | 1 | Host serial data into the block |
| sdo | output | 1 | Serial data to the host |
| convDone | input | 1 | One-cycle strobe from the converter model: result ready |
| convResult | input | 16 | Conversion result from the converter model |
| drdyN | output | 1 | Data-ready flag, low while an unread result is held |
| setupOut | output | 8 | Setup register (mode, gain, polarity, buffer, filter sync at bit 0) |
| clockOut | output | 8 | Clock register |
| powerDown | output | 1 | Power-down request from the last command |
| chanSel | output | 2 | Active channel code from the last command |
| activeOffset | output | 24 | Offset of the calibration pair of the active channel |
| activeGain | output | 24 | Gain of the calibration pair of the active channel |

## Verification
The assertions assume that each serial-clock level lasts longer than the synchronizer depth plus one system cycle. They also assume that sdi is stable from the falling edge through the following rising edge, and that convDone is a single-cycle pulse. The bench holds each serial-clock half period for eight system cycles. It changes sdi only while the serial clock is low, and it raises convDone for exactly one cycle, with no serial activity at the same time. Under these conditions every sdo change can be traced to a detected falling edge, and every drdyN change to an accepted conversion or a completed data read.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

  localparam int PAIR_COUNT = 3;

  typedef enum logic [2:0] {
    SEL_COMM   = 3'b000,
    SEL_SETUP  = 3'b001,
    SEL_CLOCK  = 3'b010,
    SEL_DATA   = 3'b011,
    SEL_TEST   = 3'b100,
    SEL_NOP    = 3'b101,
    SEL_OFFSET = 3'b110,
    SEL_GAIN   = 3'b111
  } regSel_t;

  typedef struct packed {
    logic shiftBit;
    logic captureCmd;
    logic loadRead;
    logic commitWrite;
    logic clearReady;
    logic outEnable;
  } ctrlStrobes_t;

  // channel code to calibration pair index
  function automatic logic [1:0] pairOf(input logic [1:0] chan);
    case (chan)
      2'b01:   pairOf = 2'd1;
      2'b11:   pairOf = 2'd2;
      default: pairOf = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/adc_regif_ctrl.sv
module adc_regif_ctrl
  import adc_regif_pkg::*;
#(
  parameter int REG_BITS  = 8,
  parameter int DATA_BITS = 16,
  parameter int CAL_BITS  = 24,
  parameter int SHIFT_W   = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkRise,
  input  logic         sdi,
  input  regSel_t      cmdSelNext,
  input  logic         cmdReadNext,
  output ctrlStrobes_t strobes
);

  localparam int CMD_BITS = 8;
  localparam int CNT_W    = $clog2(SHIFT_W + 1);

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  phase_t            phase, nextPhase;
  logic [CNT_W-1:0]  bitCnt, nextCnt;
  regSel_t           curSel, nextSel;
  logic              curRead, nextRead;
  logic [CNT_W-1:0]  cmdLen, curLen;

  function automatic logic [CNT_W-1:0] lenOf(input regSel_t sel, input logic rd);
    case (sel)
      SEL_COMM:               lenOf = rd ? CNT_W'(CMD_BITS) : '0;
      SEL_SETUP, SEL_CLOCK:   lenOf = CNT_W'(REG_BITS);
      SEL_DATA:               lenOf = CNT_W'(DATA_BITS);
      SEL_OFFSET, SEL_GAIN:   lenOf = CNT_W'(CAL_BITS);
      default:                lenOf = '0;
    endcase
  endfunction

  assign cmdLen = lenOf(cmdSelNext, cmdReadNext);
  assign curLen = lenOf(curSel, curRead);

  always_comb begin
    strobes           = '0;
    nextPhase         = phase;
    nextCnt           = bitCnt;
    nextSel           = curSel;
    nextRead          = curRead;
    strobes.outEnable = (phase == PH_DATA) && curRead;
    if (sclkRise) begin
      case (phase)
        PH_CMD: begin
          // a high start bit is skipped; keep waiting
          if (!(bitCnt == '0 && sdi)) begin
            strobes.shiftBit = 1'b1;
            if (bitCnt == CNT_W'(CMD_BITS - 1)) begin
              strobes.captureCmd = 1'b1;
              nextSel  = cmdSelNext;
              nextRead = cmdReadNext;
              nextCnt  = '0;
              if (cmdLen != '0) begin
                nextPhase        = PH_DATA;
                strobes.loadRead = cmdReadNext;
              end
            end else begin
              nextCnt = bitCnt + 1'b1;
            end
          end
        end
        default: begin
          strobes.shiftBit = 1'b1;
          if (bitCnt == curLen - 1'b1) begin
            nextCnt             = '0;
            nextPhase           = PH_CMD;
            strobes.commitWrite = !curRead;
            strobes.clearReady  = curRead && (curSel == SEL_DATA);
          end else begin
            nextCnt = bitCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      curSel  <= SEL_COMM;
      curRead <= 1'b0;
    end else begin
      phase   <= nextPhase;
      bitCnt  <= nextCnt;
      curSel  <= nextSel;
      curRead <= nextRead;
    end
  end

endmodule

// File: rtl/adc_regif_dp.sv
module adc_regif_dp
  import adc_regif_pkg::*;
#(
  parameter int          REG_BITS   = 8,
  parameter int          DATA_BITS  = 16,
  parameter int          CAL_BITS   = 24,
  parameter int          SHIFT_W    = 24,
  parameter logic [7:0]  SETUP_RST  = 8'h01,
  parameter logic [7:0]  CLOCK_RST  = 8'h85,
  parameter logic [23:0] OFFSET_RST = 24'h1F4000,
  parameter logic [23:0] GAIN_RST   = 24'h5761AB
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 sdi,
  input  logic                 sclkFall,
  input  logic                 convDone,
  input  logic [DATA_BITS-1:0] convResult,
  output regSel_t              cmdSelNext,
  output logic                 cmdReadNext,
  output logic                 sdo,
  output logic                 drdyN,
  output logic [REG_BITS-1:0]  setupOut,
  output logic [REG_BITS-1:0]  clockOut,
  output logic                 powerDown,
  output logic [1:0]           chanSel,
  output logic [CAL_BITS-1:0]  activeOffset,
  output logic [CAL_BITS-1:0]  activeGain
);

  logic [SHIFT_W-1:0]   shiftReg;
  logic [SHIFT_W-1:0]   wrWord;
  logic [SHIFT_W-1:0]   rdWord;
  logic [7:0]           cmdByteNext;
  logic [7:0]           commReg;
  logic [REG_BITS-1:0]  setupReg, clockReg;
  logic [DATA_BITS-1:0] dataReg;
  logic [CAL_BITS-1:0]  offsetPair [PAIR_COUNT];
  logic [CAL_BITS-1:0]  gainPair   [PAIR_COUNT];
  logic [1:0]           nextPair, curPair;
  regSel_t              curSel;
  logic                 convAccept;

  assign cmdByteNext = {shiftReg[6:0], sdi};
  assign cmdSelNext  = regSel_t'(cmdByteNext[6:4]);
  assign cmdReadNext = cmdByteNext[3];
  assign nextPair    = pairOf(cmdByteNext[1:0]);
  assign curPair     = pairOf(commReg[1:0]);
  assign curSel      = regSel_t'(commReg[6:4]);
  assign wrWord      = {shiftReg[SHIFT_W-2:0], sdi};

  // read value, left-aligned so the MSB leaves first
  always_comb begin
    case (cmdSelNext)
      SEL_COMM:   rdWord = SHIFT_W'({drdyN, cmdByteNext[6:0]}) << (SHIFT_W - 8);
      SEL_SETUP:  rdWord = SHIFT_W'(setupReg) << (SHIFT_W - REG_BITS);
      SEL_CLOCK:  rdWord = SHIFT_W'(clockReg) << (SHIFT_W - REG_BITS);
      SEL_DATA:   rdWord = SHIFT_W'(dataReg) << (SHIFT_W - DATA_BITS);
      SEL_OFFSET: rdWord = SHIFT_W'(offsetPair[nextPair]) << (SHIFT_W - CAL_BITS);
      SEL_GAIN:   rdWord = SHIFT_W'(gainPair[nextPair]) << (SHIFT_W - CAL_BITS);
      default:    rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.loadRead) begin
      shiftReg <= rdWord;
    end else if (strobes.shiftBit) begin
      shiftReg <= wrWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commReg <= '0;
    end else if (strobes.captureCmd) begin
      commReg <= {1'b0, cmdByteNext[6:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupReg <= SETUP_RST[REG_BITS-1:0];
      clockReg <= CLOCK_RST[REG_BITS-1:0];
    end else if (strobes.commitWrite) begin
      if (curSel == SEL_SETUP) setupReg <= wrWord[REG_BITS-1:0];
      if (curSel == SEL_CLOCK) clockReg <= wrWord[REG_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < PAIR_COUNT; p++) begin
        offsetPair[p] <= OFFSET_RST[CAL_BITS-1:0];
        gainPair[p]   <= GAIN_RST[CAL_BITS-1:0];
      end
    end else if (strobes.commitWrite) begin
      for (int p = 0; p < PAIR_COUNT; p++) begin
        if (curPair == 2'(p)) begin
          if (curSel == SEL_OFFSET) offsetPair[p] <= wrWord[CAL_BITS-1:0];
          if (curSel == SEL_GAIN)   gainPair[p]   <= wrWord[CAL_BITS-1:0];
        end
      end
    end
  end

  // conversions run only with filter sync low and no power-down
  assign convAccept = convDone && !setupReg[0] && !commReg[2] && drdyN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      drdyN   <= 1'b1;
    end else begin
      if (strobes.clearReady) drdyN <= 1'b1;
      if (convAccept) begin
        dataReg <= convResult;
        drdyN   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdo <= 1'b1;
    end else if (sclkFall) begin
      sdo <= strobes.outEnable ? shiftReg[SHIFT_W-1] : 1'b1;
    end
  end

  assign setupOut     = setupReg;
  assign clockOut     = clockReg;
  assign powerDown    = commReg[2];
  assign chanSel      = commReg[1:0];
  assign activeOffset = offsetPair[curPair];
  assign activeGain   = gainPair[curPair];

endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          REG_BITS    = 8,
  parameter int          DATA_BITS   = 16,
  parameter int          CAL_BITS    = 24,
  parameter logic [7:0]  SETUP_RST   = 8'h01,
  parameter logic [7:0]  CLOCK_RST   = 8'h85,
  parameter logic [23:0] OFFSET_RST  = 24'h1F4000,
  parameter logic [23:0] GAIN_RST    = 24'h5761AB
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic                 convDone,
  input  logic [DATA_BITS-1:0] convResult,
  output logic                 drdyN,
  output logic [REG_BITS-1:0]  setupOut,
  output logic [REG_BITS-1:0]  clockOut,
  output logic                 powerDown,
  output logic [1:0]           chanSel,
  output logic [CAL_BITS-1:0]  activeOffset,
  output logic [CAL_BITS-1:0]  activeGain
);

  localparam int WIDEST  = (CAL_BITS > DATA_BITS) ? CAL_BITS : DATA_BITS;
  localparam int SHIFT_W = (WIDEST > 8) ? WIDEST : 8;

  logic [SYNC_STAGES-1:0] sclkPipe, sdiPipe;
  logic                   sclkLast;
  logic                   sclkRise, sclkFall, sdiSync;
  ctrlStrobes_t           strobes;
  regSel_t                cmdSelNext;
  logic                   cmdReadNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      sdiPipe  <= '0;
      sclkLast <= 1'b0;
    end else begin
      sclkPipe <= (sclkPipe << 1) | SYNC_STAGES'(sclk);
      sdiPipe  <= (sdiPipe << 1) | SYNC_STAGES'(sdi);
      sclkLast <= sclkPipe[SYNC_STAGES-1];
    end
  end

  assign sclkRise = sclkPipe[SYNC_STAGES-1] && !sclkLast;
  assign sclkFall = !sclkPipe[SYNC_STAGES-1] && sclkLast;
  assign sdiSync  = sdiPipe[SYNC_STAGES-1];

  adc_regif_ctrl #(
    .REG_BITS (REG_BITS),
    .DATA_BITS(DATA_BITS),
    .CAL_BITS (CAL_BITS),
    .SHIFT_W  (SHIFT_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclkRise   (sclkRise),
    .sdi        (sdiSync),
    .cmdSelNext (cmdSelNext),
    .cmdReadNext(cmdReadNext),
    .strobes    (strobes)
  );

  adc_regif_dp #(
    .REG_BITS  (REG_BITS),
    .DATA_BITS (DATA_BITS),
    .CAL_BITS  (CAL_BITS),
    .SHIFT_W   (SHIFT_W),
    .SETUP_RST (SETUP_RST),
    .CLOCK_RST (CLOCK_RST),
    .OFFSET_RST(OFFSET_RST),
    .GAIN_RST  (GAIN_RST)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .sdi         (sdiSync),
    .sclkFall    (sclkFall),
    .convDone    (convDone),
    .convResult  (convResult),
    .cmdSelNext  (cmdSelNext),
    .cmdReadNext (cmdReadNext),
    .sdo         (sdo),
    .drdyN       (drdyN),
    .setupOut    (setupOut),
    .clockOut    (clockOut),
    .powerDown   (powerDown),
    .chanSel     (chanSel),
    .activeOffset(activeOffset),
    .activeGain  (activeGain)
  );

endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk (
  input logic clk,
  input logic rstN,
  input logic sdo,
  input logic drdyN,
  input logic powerDown,
  input logic convDone,
  input logic sclkFall,
  input logic captureCmd,
  input logic clearReady
);

  // R5
  sdo_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdo) |-> $past(sclkFall));

  // R2
  pd_from_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(powerDown) |-> $past(captureCmd));

  // R8
  ready_low_from_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drdyN) |-> $past(convDone));

  // R9
  ready_high_from_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drdyN) |-> $past(clearReady));

endmodule

bind adc_regif adc_regif_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sdo       (sdo),
  .drdyN     (drdyN),
  .powerDown (powerDown),
  .convDone  (convDone),
  .sclkFall  (sclkFall),
  .captureCmd(strobes.captureCmd),
  .clearReady(strobes.clearReady)
);

// File: tb/test_adc_regif.sv
module test_adc_regif;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        convDone = 1'b0;
  logic [15:0] convResult = '0;
  logic        drdyN;
  logic [7:0]  setupOut, clockOut;
  logic        powerDown;
  logic [1:0]  chanSel;
  logic [23:0] activeOffset, activeGain;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_regif i_adc_regif (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .convDone(convDone), .convResult(convResult), .drdyN(drdyN),
    .setupOut(setupOut), .clockOut(clockOut), .powerDown(powerDown),
    .chanSel(chanSel), .activeOffset(activeOffset), .activeGain(activeGain)
  );

  typedef struct packed {
    logic [7:0]  wrCmd;
    logic [7:0]  rdCmd;
    logic [4:0]  len;
    logic [23:0] val;
  } vec_t;

  // write then read back at the register's own width (R4, R5, R6)
  localparam vec_t VEC [0:6] = '{
    '{8'h10, 8'h18, 5'd8,  24'h000047},
    '{8'h20, 8'h28, 5'd8,  24'h00002A},
    '{8'h60, 8'h68, 5'd24, 24'h123456},
    '{8'h61, 8'h69, 5'd24, 24'hABCDEF},
    '{8'h63, 8'h6B, 5'd24, 24'h0F0F0F},
    '{8'h70, 8'h78, 5'd24, 24'h111111},
    '{8'h73, 8'h7B, 5'd24, 24'h333333}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic xferBit(input logic b, output logic o);
    sdi = b;
    repeat (HALF) @(negedge clk);
    o = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input int n, input logic [23:0] wv, output logic [23:0] rv);
    logic b;
    rv = '0;
    for (int i = n - 1; i >= 0; i--) begin
      xferBit(wv[i], b);
      rv[i] = b;
    end
  endtask

  task automatic pulseConv(input logic [15:0] val);
    @(negedge clk);
    convResult = val;
    convDone   = 1'b1;
    @(negedge clk);
    convDone   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [23:0] rv;
    logic        b;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    check("R1 drdyN", 24'(drdyN), 24'h1);
    check("R1 sdo", 24'(sdo), 24'h1);
    check("R1 setupOut", 24'(setupOut), 24'h01);
    check("R1 clockOut", 24'(clockOut), 24'h85);
    check("R1 activeOffset", activeOffset, 24'h1F4000);
    check("R1 activeGain", activeGain, 24'h5761AB);
    check("R1 powerDown/chanSel", {21'b0, powerDown, chanSel}, 24'h0);

    // R7 comm read: bit7 = drdyN, rest = cmd bits; R5 sdo idle high in command
    xfer(8, 24'h08, rv);
    check("R5 sdo high during command", rv, 24'hFF);
    xfer(8, 24'h0, rv);
    check("R7 comm read ready", rv, 24'h88);

    // R1 reset values through reads
    xfer(8, 24'h18, rv); xfer(8, 24'h0, rv);
    check("R1 setup read", rv, 24'h01);
    xfer(8, 24'h28, rv); xfer(8, 24'h0, rv);
    check("R1 clock read", rv, 24'h85);
    xfer(8, 24'h6B, rv); xfer(24, 24'h0, rv);
    check("R1 offset pair2 read", rv, 24'h1F4000);
    xfer(8, 24'h79, rv); xfer(24, 24'h0, rv);
    check("R1 gain pair1 read", rv, 24'h5761AB);

    // table walk: R4 widths, R5 MSB first, R6 pair targeting
    for (int k = 0; k < 7; k++) begin
      xfer(8, 24'(VEC[k].wrCmd), rv);
      xfer(int'(VEC[k].len), VEC[k].val, rv);
      xfer(8, 24'(VEC[k].rdCmd), rv);
      xfer(int'(VEC[k].len), 24'h0, rv);
      check($sformatf("R4 vector %0d readback", k), rv, VEC[k].val);
    end

    // R6 channel 10 shares pair 0
    xfer(8, 24'h6A, rv); xfer(24, 24'h0, rv);
    check("R6 ch10 offset uses pair0", rv, 24'h123456);
    check("R6 activeOffset ch10", activeOffset, 24'h123456);
    check("R6 activeGain ch10", activeGain, 24'h111111);

    // R2 power-down and channel fields of a comm write
    xfer(8, 24'h07, rv);
    check("R2 powerDown set", 24'(powerDown), 24'h1);
    check("R2 chanSel 11", 24'(chanSel), 24'h3);
    check("R6 activeOffset ch11", activeOffset, 24'h0F0F0F);
    check("R6 activeGain ch11", activeGain, 24'h333333);
    xfer(8, 24'h00, rv);
    check("R2 powerDown clear", {22'b0, powerDown, chanSel[0]}, 24'h0);

    // R3 stray high start bit is skipped
    xferBit(1'b1, b);
    xferBit(1'b1, b);
    xfer(8, 24'h20, rv); xfer(8, 24'h3C, rv);
    xfer(8, 24'h28, rv); xfer(8, 24'h0, rv);
    check("R3 skip start bit", rv, 24'h3C);

    // R4 no data phase for nop, test and comm write
    xfer(8, 24'h50, rv);
    xfer(8, 24'h40, rv);
    xfer(8, 24'h00, rv);
    xfer(8, 24'h20, rv); xfer(8, 24'h77, rv);
    check("R4 clockOut after nop/test", 24'(clockOut), 24'h77);

    // R8 conversion accept / ignore
    pulseConv(16'h5555);
    check("R8 ignored with fsync high", 24'(drdyN), 24'h1);
    xfer(8, 24'h10, rv); xfer(8, 24'h00, rv);   // fsync low
    pulseConv(16'hBEEF);
    check("R8 drdyN low after conversion", 24'(drdyN), 24'h0);
    pulseConv(16'h1234);                        // pending result, dropped
    xfer(8, 24'h10, rv); xfer(8, 24'h01, rv);   // fsync high
    check("R9 drdyN held across fsync rise", 24'(drdyN), 24'h0);
    xfer(8, 24'h08, rv); xfer(8, 24'h0, rv);
    check("R7 comm read shows pending", rv, 24'h08);
    check("R9 still low before data read", 24'(drdyN), 24'h0);
    xfer(8, 24'h38, rv); xfer(16, 24'h0, rv);
    check("R8 data read first result", rv, 24'h00BEEF);
    check("R9 drdyN cleared by read", 24'(drdyN), 24'h1);

    // R8 power-down blocks conversions
    xfer(8, 24'h10, rv); xfer(8, 24'h00, rv);   // fsync low
    xfer(8, 24'h04, rv);                        // power-down
    pulseConv(16'h7777);
    check("R8 ignored in power-down", 24'(drdyN), 24'h1);
    xfer(8, 24'h00, rv);

    // R10 data write has no effect
    pulseConv(16'hA5A5);
    xfer(8, 24'h30, rv); xfer(16, 24'hFFFF, rv);
    check("R10 drdyN after data write", 24'(drdyN), 24'h0);
    xfer(8, 24'h38, rv); xfer(16, 24'h0, rv);
    check("R10 data unchanged by write", rv, 24'h00A5A5);
    check("R9 cleared after second read", 24'(drdyN), 24'h1);
    xfer(8, 24'h10, rv); xfer(8, 24'h01, rv);
    check("R4 setup after data phases", 24'(setupOut), 24'h01);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule